// File: doc/BRIEF.md
# Reload-Controlled Watchdog Timer

A watchdog timer behind a small register window of two 32-bit words: a control/status word and a timeout word. Software programs a 16-bit tick count, sets a run bit to let the countdown proceed, and writes a self-clearing reload bit to restart the countdown from the programmed value. The countdown advances only on an external tick-enable pulse, which the system supplies at a one-second rate.

When the countdown reaches zero while the timer is running, the block latches a sticky fired flag. It then raises a one-clock request on one of two outputs. A shutdown-select bit in the control word decides whether that request is a reset request or a power-off request. A strap input marks the watchdog hardware as unusable. While the strap is high the block reports this in the control word and never expires.

Register reads are combinational from the byte offset. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `wdt_reload_ctl`

## Requirements
- R1: The control word is at byte offset 0x0 and the timeout word at byte offset 0x4. Every other offset reads 0, and writes to it change nothing.
- R2: The timeout word stores write-data bits 15:0. A read returns that value in bits 15:0 and zero in bits 31:16.
- R3: Control bit 0 (run) reads back as written. While run is 0 the countdown is frozen. Setting run again resumes the countdown from where it stopped.
- R4: Control bit 7 (reload) always reads 0. Writing 1 to it loads the countdown from the timeout word. A reload with run at 0 starts nothing. The countdown is 0 after reset, so running with no reload never expires.
- R5: A programmed timeout of 0 is loaded as 1 tick.
- R6: While run is 1, each tick pulse decrements the countdown by one. With a timeout of T, expiry happens on the T-th tick after the reload.
- R7: Control bit 1 (fired) is set by an expiry and stays set across run changes. Writing 1 to bit 1 clears it, and writing 0 to bit 1 has no effect. An expiry in the same cycle as a clear leaves it set.
- R8: On expiry, reset_req is high for exactly one clock if control bit 2 (shutdown) is 0, or shutdown_req is high for exactly one clock if bit 2 is 1. The other request stays low. The countdown then holds at 0 and no further request follows without a reload.
- R9: Control bit 3 reads the disable strap, and writes to bit 3 are ignored. While the strap is high the countdown does not move and no expiry, fired flag or request occurs.
- R10: Control bits 6:4 and 31:8 read 0 whatever is written to them.
- R11: A reload written in the same cycle as a tick pulse takes priority. The tick is dropped and no expiry occurs in that cycle.
- R12: After reset, both words read 0 (apart from the strap in bit 3) and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock tick pulse (nominally once per second) |
| disable_strap | input | 1 | High marks the watchdog as unusable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| reset_req | output | 1 | One-clock reset request on expiry |
| shutdown_req | output | 1 | One-clock power-off request on expiry |

## Verification
The bench goes after the exact tick on which expiry happens, including a timeout of 0 and a pause with run cleared part-way through. An off-by-one countdown would move the request by a tick, and a design that drops the zero case would never expire. A reload arriving on the same cycle as the final tick must suppress expiry; with the priority reversed, a spurious reset request would appear. The bench also checks that the fired flag survives writes of 0 and run changes. It checks that a second request never follows the first, and that a high strap freezes the countdown instead of merely masking the output.

// File: rtl/wdt_reload_pkg.sv
package wdt_reload_pkg;

   // Control word bit positions (software decodes these)
   localparam int unsigned CB_RUN    = 0;
   localparam int unsigned CB_FIRED  = 1;
   localparam int unsigned CB_SHUT   = 2;
   localparam int unsigned CB_DIS    = 3;
   localparam int unsigned CB_RELOAD = 7;

   // Byte offsets of the two words
   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_TMO   = 4;

   typedef enum logic [1:0] {
      ACT_NONE     = 2'd0,
      ACT_RESET    = 2'd1,
      ACT_POWEROFF = 2'd2
   } wdt_action_e;

endpackage

// File: rtl/wdt_reload_regs.sv
module wdt_reload_regs
   import wdt_reload_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned CTRL_ADR = OFS_CTRL,
   parameter int unsigned TMO_ADR  = OFS_TMO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              strap,
   input  logic              fired,
   output logic              run,
   output logic              shut,
   output logic [CNT_W-1:0]  tmo,
   output logic              reload,
   output logic              fired_clr,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADR);
   localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(TMO_ADR);

   logic hit_ctrl;
   logic hit_tmo;
   logic wr_ctrl;
   logic wr_tmo;

   assign hit_ctrl = (addr == A_CTRL);
   assign hit_tmo  = (addr == A_TMO);
   assign wr_ctrl  = wr_en && hit_ctrl;
   assign wr_tmo   = wr_en && hit_tmo;

   // Reload and fired-clear are strobes derived from the write
   assign reload    = wr_ctrl && wdata[CB_RELOAD];
   assign fired_clr = wr_ctrl && wdata[CB_FIRED];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         shut <= 1'b0;
      end else if (wr_ctrl) begin
         run  <= wdata[CB_RUN];
         shut <= wdata[CB_SHUT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo <= '0;
      end else if (wr_tmo) begin
         tmo <= wdata[CNT_W-1:0];
      end
   end

   // Readback: reserved and self-clearing bits return zero
   logic [DATA_W-1:0] ctrl_view;
   logic [DATA_W-1:0] tmo_view;

   always_comb begin
      ctrl_view           = '0;
      ctrl_view[CB_RUN]   = run;
      ctrl_view[CB_FIRED] = fired;
      ctrl_view[CB_SHUT]  = shut;
      ctrl_view[CB_DIS]   = strap;
   end

   generate
      if (CNT_W == DATA_W) begin : g_tmo_full
         assign tmo_view = tmo;
      end else begin : g_tmo_pad
         assign tmo_view = {{(DATA_W-CNT_W){1'b0}}, tmo};
      end
   endgenerate

   always_comb begin
      unique case (1'b1)
         hit_ctrl: rdata = ctrl_view;
         hit_tmo:  rdata = tmo_view;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/wdt_reload_counter.sv
module wdt_reload_counter #(
   parameter int unsigned CNT_W       = 16,
   parameter bit          ZERO_AS_ONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic             tick,
   input  logic             reload,
   input  logic [CNT_W-1:0] tmo,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] load_val;
   logic             advance;

   generate
      if (ZERO_AS_ONE) begin : g_zero_one
         assign load_val = (tmo == '0) ? ONE : tmo;
      end else begin : g_zero_raw
         assign load_val = tmo;
      end
   endgenerate

   // Reload has priority over the tick in the same cycle
   assign advance = run && !hold && tick && !reload && (cnt != '0);
   assign expire  = advance && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (reload) begin
         cnt <= load_val;
      end else if (advance) begin
         cnt <= cnt - ONE;
      end
   end

endmodule

// File: rtl/wdt_reload_action.sv
module wdt_reload_action
   import wdt_reload_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic shut,
   input  logic fired_clr,
   output logic fired,
   output logic reset_req,
   output logic shutdown_req
);

   wdt_action_e act_q;
   wdt_action_e act_d;

   always_comb begin
      act_d = ACT_NONE;
      if (expire) act_d = shut ? ACT_POWEROFF : ACT_RESET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= ACT_NONE;
         fired <= 1'b0;
      end else begin
         act_q <= act_d;
         if (expire)         fired <= 1'b1;
         else if (fired_clr) fired <= 1'b0;
      end
   end

   assign reset_req    = (act_q == ACT_RESET);
   assign shutdown_req = (act_q == ACT_POWEROFF);

endmodule

// File: rtl/wdt_reload_ctl.sv
module wdt_reload_ctl
   import wdt_reload_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned CNT_W       = 16,
   parameter bit          ZERO_AS_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              disable_strap,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              reset_req,
   output logic              shutdown_req
);

   localparam int unsigned MIN_DATA_W = CB_RELOAD + 1;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
         $error("wdt_reload_ctl: DATA_W too narrow for the control bits");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("wdt_reload_ctl: CNT_W out of range");
      end
      if ((1 << ADDR_W) <= OFS_TMO) begin : g_bad_addr_w
         $error("wdt_reload_ctl: ADDR_W cannot reach the timeout word");
      end
   endgenerate

   logic             run_q;
   logic             shut_q;
   logic             fired_q;
   logic [CNT_W-1:0] tmo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             reload_w;
   logic             fired_clr_w;
   logic             expire_w;

   wdt_reload_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .CTRL_ADR (OFS_CTRL),
      .TMO_ADR  (OFS_TMO)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .strap     (disable_strap),
      .fired     (fired_q),
      .run       (run_q),
      .shut      (shut_q),
      .tmo       (tmo_q),
      .reload    (reload_w),
      .fired_clr (fired_clr_w),
      .rdata     (rdata)
   );

   wdt_reload_counter #(
      .CNT_W       (CNT_W),
      .ZERO_AS_ONE (ZERO_AS_ONE)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .hold   (disable_strap),
      .tick   (tick_en),
      .reload (reload_w),
      .tmo    (tmo_q),
      .cnt    (cnt_q),
      .expire (expire_w)
   );

   wdt_reload_action u_act (
      .clk          (clk),
      .rst_n        (rst_n),
      .expire       (expire_w),
      .shut         (shut_q),
      .fired_clr    (fired_clr_w),
      .fired        (fired_q),
      .reset_req    (reset_req),
      .shutdown_req (shutdown_req)
   );

endmodule

// File: rtl/wdt_reload_checker.sv
module wdt_reload_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              disable_strap,
   input logic              run,
   input logic              fired,
   input logic [CNT_W-1:0]  cnt,
   input logic              reset_req,
   input logic              shutdown_req
);

   logic ctrl_wr;
   assign ctrl_wr = wr_en && (addr == '0);

   p_req_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(reset_req && shutdown_req));

   p_reset_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   p_poweroff_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |=> !shutdown_req);

   p_req_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req || shutdown_req) |-> (cnt == '0));

   p_req_sets_fired_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req || shutdown_req) |-> fired);

   p_fired_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fired) && !($past(ctrl_wr) && $past(wdata[1]))) |-> fired);

   p_frozen_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run) && !($past(ctrl_wr) && $past(wdata[7]))) |-> (cnt == $past(cnt)));

   p_strap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(disable_strap) |-> (!reset_req && !shutdown_req));

endmodule

bind wdt_reload_ctl wdt_reload_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .addr          (addr),
   .wdata         (wdata),
   .disable_strap (disable_strap),
   .run           (run_q),
   .fired         (fired_q),
   .cnt           (cnt_q),
   .reset_req     (reset_req),
   .shutdown_req  (shutdown_req)
);

// File: tb/sim_wdt_reload_ctl.sv
`timescale 1ns/1ps
module sim_wdt_reload_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        disable_strap = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        reset_req;
   logic        shutdown_req;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rr_cnt = 0;
   int sr_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdt_reload_ctl u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .disable_strap(disable_strap),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .reset_req(reset_req), .shutdown_req(shutdown_req)
   );

   // Behavioural reference model
   int m_run, m_fired, m_shut, m_tmo, m_cnt, m_rr, m_sr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_fired = 0; m_shut = 0; m_tmo = 0; m_cnt = 0; m_rr = 0; m_sr = 0;
      end else begin
         int rel, clr, exp_now;
         rel = (wr_en && addr == 3'd0 && wdata[7]) ? 1 : 0;
         clr = (wr_en && addr == 3'd0 && wdata[1]) ? 1 : 0;
         exp_now = (!rel && m_run != 0 && !disable_strap && tick_en && m_cnt == 1) ? 1 : 0;
         m_rr = (exp_now != 0 && m_shut == 0) ? 1 : 0;
         m_sr = (exp_now != 0 && m_shut != 0) ? 1 : 0;
         if (exp_now != 0) m_fired = 1;
         else if (clr != 0) m_fired = 0;
         if (rel != 0) m_cnt = (m_tmo == 0) ? 1 : m_tmo;
         else if (m_run != 0 && !disable_strap && tick_en && m_cnt != 0) m_cnt = m_cnt - 1;
         if (wr_en && addr == 3'd0) begin
            m_run = wdata[0] ? 1 : 0;
            m_shut = wdata[2] ? 1 : 0;
         end
         if (wr_en && addr == 3'd4) m_tmo = int'(wdata[15:0]);
      end
   end

   function automatic logic [31:0] model_rd(input logic [2:0] a);
      logic [31:0] v;
      v = 32'd0;
      if (a == 3'd0) begin
         v[0] = (m_run != 0);
         v[1] = (m_fired != 0);
         v[2] = (m_shut != 0);
         v[3] = disable_strap;
      end else if (a == 3'd4) begin
         v = 32'(m_tmo);
      end
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, expv, cyc);
      end
   endtask

   // Per-cycle comparison, well clear of both clock edges
   always @(posedge clk) begin
      cyc++;
      #2;
      if (rst_n && !done) begin
         check("R8 reset_req", {31'd0, reset_req}, 32'(m_rr));
         check("R8 shutdown_req", {31'd0, shutdown_req}, 32'(m_sr));
         check("R1 rdata", rdata, model_rd(addr));
         if (reset_req) rr_cnt++;
         if (shutdown_req) sr_cnt++;
      end
   end

   always @(posedge clk) begin
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0; wdata = 32'd0;
   endtask

   task automatic wr_tick(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; tick_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; wdata = 32'd0; tick_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk); wr_en = 1'b0; addr = a;
      #1 v = rdata;
   endtask

   initial begin
      logic [31:0] v;
      int base_r, base_s;
      repeat (3) @(negedge clk);
      // R12: reset state
      rd(3'd0, v); check("R12 ctrl after reset", v, 32'd0);
      rd(3'd4, v); check("R12 tmo after reset", v, 32'd0);
      check("R12 requests low", {30'd0, reset_req, shutdown_req}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4: running with no reload never expires (countdown starts at 0)
      base_r = rr_cnt;
      wr(3'd0, 32'h1); ticks(4);
      check("R4 no expiry without reload", 32'(rr_cnt - base_r), 32'd0);
      wr(3'd0, 32'h0);

      // R2: timeout width
      wr(3'd4, 32'h0001_2345);
      rd(3'd4, v); check("R2 upper bits dropped", v, 32'h0000_2345);
      wr(3'd4, 32'd5);
      rd(3'd4, v); check("R2 readback", v, 32'd5);

      // R10: reserved bits read zero
      wr(3'd0, 32'hFFFF_FF70);
      rd(3'd0, v); check("R10 reserved bits", v, 32'd0);

      // R4: reload with run clear starts nothing, reload reads 0
      base_r = rr_cnt;
      wr(3'd4, 32'd2); wr(3'd0, 32'h80);
      rd(3'd0, v); check("R4 reload reads 0", v[7], 1'b0);
      ticks(6);
      check("R4 reload without run", 32'(rr_cnt - base_r), 32'd0);

      // R6/R8: expiry on the T-th tick, reset request once
      base_r = rr_cnt; base_s = sr_cnt;
      wr(3'd4, 32'd3); wr(3'd0, 32'h81);
      ticks(2);
      check("R6 no expiry before T", 32'(rr_cnt - base_r), 32'd0);
      ticks(1);
      check("R6 expiry at T", 32'(rr_cnt - base_r), 32'd1);
      ticks(4);
      check("R8 single reset request", 32'(rr_cnt - base_r), 32'd1);
      check("R8 no poweroff request", 32'(sr_cnt - base_s), 32'd0);

      // R7: fired sticky, write 0 no effect, W1C
      rd(3'd0, v); check("R7 fired set", v[1], 1'b1);
      wr(3'd0, 32'h0); wr(3'd0, 32'h1);
      rd(3'd0, v); check("R7 fired survives write 0 and run change", v[1], 1'b1);
      wr(3'd0, 32'h2);
      rd(3'd0, v); check("R7 fired cleared by write 1", v[1], 1'b0);

      // R8: shutdown select
      base_r = rr_cnt; base_s = sr_cnt;
      wr(3'd4, 32'd2); wr(3'd0, 32'h85);
      ticks(4);
      check("R8 poweroff request once", 32'(sr_cnt - base_s), 32'd1);
      check("R8 no reset request", 32'(rr_cnt - base_r), 32'd0);
      wr(3'd0, 32'h2);

      // R5: zero timeout acts as one tick
      base_r = rr_cnt;
      wr(3'd4, 32'd0); wr(3'd0, 32'h81);
      ticks(1);
      check("R5 zero timeout expires on first tick", 32'(rr_cnt - base_r), 32'd1);
      wr(3'd0, 32'h2);

      // R3: pause and resume
      base_r = rr_cnt;
      wr(3'd4, 32'd4); wr(3'd0, 32'h81);
      ticks(2); wr(3'd0, 32'h0); ticks(5);
      check("R3 frozen while stopped", 32'(rr_cnt - base_r), 32'd0);
      wr(3'd0, 32'h1);
      rd(3'd0, v); check("R3 run readback", v[0], 1'b1);
      ticks(1);
      check("R3 resumes from remainder", 32'(rr_cnt - base_r), 32'd0);
      ticks(1);
      check("R3 expires after remainder", 32'(rr_cnt - base_r), 32'd1);
      wr(3'd0, 32'h2);

      // R9: strap
      wr(3'd0, 32'h8);
      rd(3'd0, v); check("R9 bit 3 not writable", v[3], 1'b0);
      @(negedge clk); disable_strap = 1'b1;
      base_r = rr_cnt;
      wr(3'd4, 32'd2); wr(3'd0, 32'h81);
      ticks(5);
      rd(3'd0, v); check("R9 strap reads back", v[3], 1'b1);
      check("R9 no fired while strapped", v[1], 1'b0);
      check("R9 no request while strapped", 32'(rr_cnt - base_r), 32'd0);
      @(negedge clk); disable_strap = 1'b0;
      ticks(2);
      check("R9 countdown held, not masked", 32'(rr_cnt - base_r), 32'd1);
      wr(3'd0, 32'h2);

      // R11: reload beats tick
      base_r = rr_cnt;
      wr(3'd4, 32'd1); wr(3'd0, 32'h81);
      wr_tick(3'd0, 32'h81);
      repeat (2) @(negedge clk);
      check("R11 reload wins over tick", 32'(rr_cnt - base_r), 32'd0);
      ticks(1);
      check("R11 expires on following tick", 32'(rr_cnt - base_r), 32'd1);
      wr(3'd0, 32'h2);

      // R1: unmapped offset
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, v); check("R1 unmapped reads 0", v, 32'd0);
      rd(3'd0, v); check("R1 unmapped write ignored (ctrl)", v, 32'd0);
      rd(3'd4, v); check("R1 unmapped write ignored (tmo)", v, 32'd1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule